// File: doc/BRIEF.md
# Back-Porch Level Clamp

This block takes the 8-bit digitised composite video stream and removes the line-to-line wander of the blanking level. On every line, the sync logic raises a gate during the back porch. The block averages the first sixteen samples inside that gate. When the gate closes, it adopts the average as the line's measured blanking level. Every later sample is then shifted by the difference between that level and a fixed blanking code. The code depends on the selected video standard.

A programmable sync-tip floor stops clamped sync tips from sinking below a chosen code. The measured level is also presented as an 8-bit status value, so that a host or a gain loop can watch the raw blanking amplitude. One enable input turns the whole correction on or off. When it is off, the video passes through untouched. The output is registered once.

Top module: `porch_clamp`

## Requirements
- R1: With the clamp enabled and a level measured, `video_out` equals `sample_in − blank_level + B`, one clock after the sample is presented. B is 0x3C when `fmt_pal` is 0 (NTSC) and 0x40 when `fmt_pal` is 1 (PAL).
- R2: With `clamp_on` low, `video_out` equals `sample_in` one clock later, whatever the level, format or tip code.
- R3: A corrected value above 0xFF is output as 0xFF. A corrected value below zero is output as 0x00, before the floor of R4 is applied.
- R4: With the clamp active, an output below the floor is replaced by the floor. The floor is `tip_code` plus 0 for NTSC and plus 4 for PAL. A `tip_code` of 3 therefore gives 0x03 for NTSC and 0x07 for PAL.
- R5: The measured level is the sum of the first 16 samples taken while `porch_gate` is high, shifted right by 4 (truncated). It is adopted at the clock edge where `porch_gate` is first seen low. The sample presented in that same cycle still uses the previous level.
- R6: A gate window shorter than 16 samples leaves the measured level unchanged. Samples after the sixteenth in a window are ignored.
- R7: After reset, until the first complete measurement, an enabled clamp passes `sample_in` through unchanged.
- R8: `blank_level` always shows the most recently adopted measured level. Its value is 0x00 after reset.
- R9: While `rst_n` is low, `video_out` and `blank_level` are 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_in | input | 8 | Digitised composite video sample |
| porch_gate | input | 1 | High during the back-porch window of a line |
| fmt_pal | input | 1 | 0 selects NTSC codes, 1 selects PAL codes |
| clamp_on | input | 1 | Enables the level correction |
| tip_code | input | 4 | Sync-tip floor value before the format bias |
| video_out | output | 8 | Clamped video, registered |
| blank_level | output | 8 | Most recently measured blanking level |

## Verification
Two operations can occur in the same cycle: the level update at the closing edge of the gate, and the correction of the sample presented in that cycle. The bench drives a sample in the cycle where the gate first goes low. It expects that sample to be corrected with the old level, and the very next sample to be corrected with the new level. It reads `blank_level` in the same cycle to confirm when the update took effect. Gate windows that are too short, and windows carrying extra out-of-range samples, check that only full 16-sample windows reach the adopted level.

// File: rtl/bpc_pkg.sv
package bpc_pkg;

    typedef enum logic {
        FMT_NTSC = 1'b0,
        FMT_PAL  = 1'b1
    } vid_fmt_e;

    // Blanking target code for each standard
    function automatic logic [7:0] blank_code(vid_fmt_e fmt);
        return (fmt == FMT_PAL) ? 8'h40 : 8'h3C;
    endfunction

    // Offset added to the programmed tip value for each standard
    function automatic logic [7:0] tip_bias(vid_fmt_e fmt);
        return (fmt == FMT_PAL) ? 8'h04 : 8'h00;
    endfunction

endpackage

// File: rtl/porch_meter.sv
module porch_meter #(
    parameter int DATA_W   = 8,
    parameter int AVG_LOG2 = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] sample,
    input  logic              gate,
    output logic [DATA_W-1:0] level,
    output logic              level_ok
);
    localparam int AVG_N = 1 << AVG_LOG2;
    localparam int SUM_W = DATA_W + AVG_LOG2;
    localparam int CNT_W = AVG_LOG2 + 1;

    typedef struct packed {
        logic [SUM_W-1:0]  sum;
        logic [CNT_W-1:0]  cnt;
        logic              gate_prev;
        logic [DATA_W-1:0] level;
        logic              ok;
    } meter_t;

    meter_t m_d, m_q;
    logic   closing;

    assign closing = m_q.gate_prev && !gate;

    always_comb begin
        m_d           = m_q;
        m_d.gate_prev = gate;
        if (gate) begin
            if (m_q.cnt < CNT_W'(AVG_N)) begin
                m_d.sum = m_q.sum + SUM_W'(sample);
                m_d.cnt = m_q.cnt + CNT_W'(1);
            end
        end else begin
            if (closing && (m_q.cnt == CNT_W'(AVG_N))) begin
                m_d.level = m_q.sum[SUM_W-1:AVG_LOG2];
                m_d.ok    = 1'b1;
            end
            m_d.sum = '0;
            m_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q <= '0;
        end else begin
            m_q <= m_d;
        end
    end

    assign level    = m_q.level;
    assign level_ok = m_q.ok;

    // R5: the level moves only at the edge that closes a gate window
    p_level_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !closing |=> $stable(level));

    // R6: no more than AVG_N samples enter one average
    p_cnt_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        m_q.cnt <= CNT_W'(AVG_N));

    // R7: a measurement becomes valid only after a gate has closed
    p_ok_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(level_ok) |-> $past(closing));

endmodule

// File: rtl/clamp_math.sv
module clamp_math
    import bpc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int TIP_W  = 4
) (
    input  logic [DATA_W-1:0] sample,
    input  logic [DATA_W-1:0] level,
    input  vid_fmt_e          fmt,
    input  logic [TIP_W-1:0]  tip,
    input  logic              enable,
    input  logic              level_ok,
    output logic [DATA_W-1:0] result
);
    localparam int EXT_W = DATA_W + 2;
    localparam logic signed [EXT_W-1:0] TOP_S = $signed({2'b00, {DATA_W{1'b1}}});

    logic signed [EXT_W-1:0] raw_s;
    logic [DATA_W-1:0]       sat_v;
    logic [DATA_W-1:0]       floor_v;

    always_comb begin
        raw_s = $signed({2'b00, sample})
              - $signed({2'b00, level})
              + $signed({2'b00, DATA_W'(blank_code(fmt))});
        floor_v = DATA_W'(tip) + DATA_W'(tip_bias(fmt));

        if (raw_s[EXT_W-1]) begin
            sat_v = '0;
        end else if (raw_s > TOP_S) begin
            sat_v = '1;
        end else begin
            sat_v = raw_s[DATA_W-1:0];
        end

        if (!enable || !level_ok) begin
            result = sample;
        end else if (sat_v < floor_v) begin
            result = floor_v;
        end else begin
            result = sat_v;
        end
    end

endmodule

// File: rtl/porch_clamp.sv
module porch_clamp
    import bpc_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int TIP_W    = 4,
    parameter int AVG_LOG2 = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] sample_in,
    input  logic              porch_gate,
    input  logic              fmt_pal,
    input  logic              clamp_on,
    input  logic [TIP_W-1:0]  tip_code,
    output logic [DATA_W-1:0] video_out,
    output logic [DATA_W-1:0] blank_level
);
    typedef struct packed {
        logic [DATA_W-1:0] video;
    } out_t;

    out_t              o_d, o_q;
    logic [DATA_W-1:0] lvl;
    logic              lvl_ok;
    logic [DATA_W-1:0] clamped;
    vid_fmt_e          fmt;

    assign fmt = vid_fmt_e'(fmt_pal);

    porch_meter #(
        .DATA_W  (DATA_W),
        .AVG_LOG2(AVG_LOG2)
    ) u_meter (
        .clk     (clk),
        .rst_n   (rst_n),
        .sample  (sample_in),
        .gate    (porch_gate),
        .level   (lvl),
        .level_ok(lvl_ok)
    );

    clamp_math #(
        .DATA_W(DATA_W),
        .TIP_W (TIP_W)
    ) u_math (
        .sample  (sample_in),
        .level   (lvl),
        .fmt     (fmt),
        .tip     (tip_code),
        .enable  (clamp_on),
        .level_ok(lvl_ok),
        .result  (clamped)
    );

    always_comb begin
        o_d       = o_q;
        o_d.video = clamped;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign video_out   = o_q.video;
    assign blank_level = lvl;

    // R2: disabled clamp is a one-cycle delay line
    p_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(clamp_on) |-> video_out == $past(sample_in));

    // R7: nothing measured yet means no correction
    p_unmeasured_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(lvl_ok) |-> video_out == $past(sample_in));

    // R1: a sample equal to the measured level lands on the blanking code
    p_blank_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(clamp_on && lvl_ok && (sample_in == blank_level))
        |-> video_out == DATA_W'(blank_code(vid_fmt_e'($past(fmt_pal)))));

    // R4: active output never drops under the sync-tip floor
    p_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(clamp_on && lvl_ok)
        |-> video_out >= (DATA_W'($past(tip_code))
                          + DATA_W'(tip_bias(vid_fmt_e'($past(fmt_pal))))));

endmodule

// File: tb/porch_clamp_test.sv
module porch_clamp_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] s;
    logic       g;
    logic       pal;
    logic       en;
    logic [3:0] tip;
    logic [7:0] vout;
    logic [7:0] blvl;
    int         checks = 0;
    int         fails  = 0;

    always #2 clk = ~clk;

    porch_clamp uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_in  (s),
        .porch_gate (g),
        .fmt_pal    (pal),
        .clamp_on   (en),
        .tip_code   (tip),
        .video_out  (vout),
        .blank_level(blvl)
    );

    // {fmt_pal, clamp_on, tip_code, sample}; evaluated with level 0x50
    localparam logic [13:0] VEC [0:11] = '{
        {1'b0, 1'b1, 4'd3,  8'h50},
        {1'b1, 1'b1, 4'd3,  8'h50},
        {1'b0, 1'b1, 4'd3,  8'hF0},
        {1'b1, 1'b1, 4'd3,  8'hF0},
        {1'b0, 1'b1, 4'd3,  8'h17},
        {1'b0, 1'b1, 4'd3,  8'h16},
        {1'b1, 1'b1, 4'd3,  8'h18},
        {1'b1, 1'b1, 4'd3,  8'h00},
        {1'b0, 1'b1, 4'd0,  8'h00},
        {1'b0, 1'b1, 4'd15, 8'h00},
        {1'b0, 1'b0, 4'd3,  8'h00},
        {1'b1, 1'b0, 4'd3,  8'hAB}
    };

    function automatic int raw_of(input int smp, input int lv, input logic p);
        return smp - lv + (p ? 64 : 60);
    endfunction

    function automatic logic [7:0] model(input int smp, input int lv, input logic p,
                                         input logic e, input int tp, input logic ok);
        int v;
        int fl;
        if (!e || !ok) return smp[7:0];
        v  = raw_of(smp, lv, p);
        if (v > 255) v = 255;
        if (v < 0)   v = 0;
        fl = tp + (p ? 4 : 0);
        if (v < fl) v = fl;
        return v[7:0];
    endfunction

    function automatic string tag_of(input int smp, input int lv, input logic p,
                                     input logic e, input int tp);
        int v;
        v = raw_of(smp, lv, p);
        if (!e) return "R2";
        if (v < tp + (p ? 4 : 0)) return "R4";
        if (v < 0 || v > 255) return "R3";
        return "R1";
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic step(input logic [7:0] v, input logic gv);
        s = v;
        g = gv;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        s = 8'h00; g = 1'b0; pal = 1'b0; en = 1'b1; tip = 4'd3;
        repeat (3) @(posedge clk);
        @(negedge clk);
        s = 8'h77;
        #1;
        check("R9 video", vout, 8'h00);
        check("R9 level", blvl, 8'h00);
        rst_n = 1'b1;

        // R7: enabled, but no measurement yet
        step(8'h77, 1'b0);
        check("R7", vout, 8'h77);

        // R5: 8 x 0x50 and 8 x 0x51 average to 0x50 (truncated); R6: extra 0xFF ignored
        for (int i = 0; i < 8; i++) step(8'h50, 1'b1);
        for (int i = 0; i < 8; i++) step(8'h51, 1'b1);
        for (int i = 0; i < 4; i++) step(8'hFF, 1'b1);
        step(8'h90, 1'b0);
        check("R5 old level in closing cycle", vout, 8'h90);
        check("R8 level readback", blvl, 8'h50);
        step(8'h90, 1'b0);
        check("R5 new level next cycle", vout, 8'h7C);

        // table walk at level 0x50
        for (int i = 0; i < 12; i++) begin
            {pal, en, tip, s} = VEC[i];
            step(s, 1'b0);
            check(tag_of(s, 'h50, pal, en, tip), vout,
                  model(s, 'h50, pal, en, tip, 1'b1));
        end

        // R6: short window keeps the old level
        pal = 1'b0; en = 1'b1; tip = 4'd3;
        for (int i = 0; i < 10; i++) step(8'h20, 1'b1);
        step(8'h00, 1'b0);
        step(8'h00, 1'b0);
        check("R6 short gate", blvl, 8'h50);

        // new level 0x10, then saturation
        for (int i = 0; i < 16; i++) step(8'h10, 1'b1);
        step(8'h00, 1'b0);
        check("R8 new level", blvl, 8'h10);
        pal = 1'b1;
        step(8'hF0, 1'b0);
        check("R3 high saturation PAL", vout, 8'hFF);
        pal = 1'b0;
        step(8'hE0, 1'b0);
        check("R3 high saturation NTSC", vout, 8'hFF);
        en = 1'b0;
        step(8'hF0, 1'b0);
        check("R2 bypass at low level", vout, 8'hF0);

        // R2 with gate active: bypass holds, measurement still runs
        for (int i = 0; i < 16; i++) step(8'h30, 1'b1);
        check("R2 bypass during gate", vout, 8'h30);
        step(8'h31, 1'b0);
        step(8'h31, 1'b0);
        check("R8 measured while bypassed", blvl, 8'h30);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule